// File: doc/BRIEF.md
# Cascaded Bidirectional Column Sampler

This block is the digital front end of a display column driver. On each rising edge of the shift clock it takes three colour words, X, Y and Z, into the next position of a sampling row. A line begins when a start pulse arrives. Once the last position is filled, the block raises a one-period cascade pulse so that the next driver in a chain can begin its own line. A separate load strobe copies the whole sampling row at once into a hold row, and the hold row drives the column outputs. This lets one line be shown while the next one is being sampled.

A direction input sets the fill order and the colour order. It also decides which of the two bidirectional side pins takes the start pulse and which one drives the cascade pulse. Each side pin is brought out as separate in, out and output-enable signals. A reduced-width input drops a fixed group of middle positions from both the fill sequence and the outputs. Board designs that leave this input unused should tie it high, which selects the reduced width.

Top module: `colsamp_top`

## Requirements
- R1: While reset is asserted and after it is released, every column output bit is zero, both side-pin outputs are low and no sampling is in progress.
- R2: When `dirRight` is 1, `pinLeftIn` is the start input and `pinRightOe` is 1. The clock edge that sees the start pulse captures into position 1. Each later edge captures into the next higher position. The `busX`, `busY` and `busZ` words go to the X, Y and Z slots of that position.
- R3: When `dirRight` is 0, `pinRightIn` is the start input and `pinLeftOe` is 1. Filling begins at the last position and moves downward. `busX` is stored into the Z slot, `busZ` into the X slot, and `busY` into the Y slot.
- R4: After the last position of a line is captured, sampling stops. Data on the buses changes no part of the sampling row until a new start pulse arrives.
- R5: The cascade pulse goes high just after the edge that captures the final position and stays high for exactly one clock period. It is driven on the side pin that is not the start input, and the other pin's output stays low.
- R6: When `reducedMode` is 1, the SKIP_COUNT positions starting at position SKIP_FIRST are never written, the line holds NUM_POS-SKIP_COUNT captures, and those positions read as zero on `colOut`.
- R7: When `reducedMode` is 0, a line covers all NUM_POS positions and every position drives its held value.
- R8: On a rising edge of `loadStrobe`, the hold row takes a copy of the sampling row as it stood before that clock edge, even if the line is only partly filled. Keeping the strobe high causes no further copies.
- R9: While no load rising edge occurs, `colOut` stays unchanged, including while a line is being sampled.
- R10: A start pulse that arrives in the middle of a line restarts filling at the first position for the current direction.
- R11: Position p, counting from 1, occupies `colOut` bits starting at (p-1)*3*DW. Within a position, the X slot is lowest, then Y, and Z is highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous reset, active high |
| dirRight | input | 1 | 1: fill upward with the left pin as start input; 0: fill downward with the right pin as start input |
| reducedMode | input | 1 | 1: skip the middle group of positions |
| loadStrobe | input | 1 | A rising edge copies the sampling row into the hold row |
| busX | input | DW | X colour word |
| busY | input | DW | Y colour word |
| busZ | input | DW | Z colour word |
| pinLeftIn | input | 1 | Left side pin, input value |
| pinLeftOut | output | 1 | Left side pin, driven value |
| pinLeftOe | output | 1 | Left side pin, output enable |
| pinRightIn | input | 1 | Right side pin, input value |
| pinRightOut | output | 1 | Right side pin, driven value |
| pinRightOe | output | 1 | Right side pin, output enable |
| colOut | output | NUM_POS*3*DW | Held colour values for all positions |

## Verification
The bench builds the block with 8 positions, 6-bit colour words, and a skipped group of two positions starting at position 4. At this size the whole output row can be checked after every load. Every combination of direction and width mode is run, so each pointer step and both jumps across the skipped group are exercised. Expected row contents are computed from a per-line arithmetic pattern of line and capture index. This exposes any misplaced, swapped or stray write, and also covers partial loads, held strobes and mid-line restarts.

// File: rtl/colsamp_pkg.sv
package colsamp_pkg;
  typedef struct packed {
    logic wrEn;      // write the current position this edge
    logic swapColor; // reversed colour order
    logic loadHold;  // copy sampling row into hold row
  } sampCtrl_t;
endpackage

// File: rtl/colsamp_ctrl.sv
module colsamp_ctrl
  import colsamp_pkg::*;
#(
  parameter int NUM_POS    = 103,
  parameter int SKIP_FIRST = 51,
  parameter int SKIP_COUNT = 3,
  localparam int IDX_W = $clog2(NUM_POS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dirRight,
  input  logic             reducedMode,
  input  logic             startIn,
  input  logic             loadStrobe,
  output sampCtrl_t        ctrl,
  output logic [IDX_W-1:0] wrIdx,
  output logic             cascPulse
);
  localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(NUM_POS - 1);
  localparam logic [IDX_W-1:0] SKIP_LO     = IDX_W'(SKIP_FIRST - 1);
  localparam logic [IDX_W-1:0] SKIP_HI     = IDX_W'(SKIP_FIRST + SKIP_COUNT - 2);
  localparam logic [IDX_W-1:0] SKIP_BEFORE = IDX_W'(SKIP_FIRST - 2);
  localparam logic [IDX_W-1:0] SKIP_AFTER  = IDX_W'(SKIP_FIRST + SKIP_COUNT - 1);

  logic             active;
  logic [IDX_W-1:0] ptr;
  logic             cascReg;
  logic             loadPrev;
  logic [IDX_W-1:0] firstIdx, lastIdx, curIdx, nextIdx;
  logic             writing, isLast;

  function automatic logic inSkip(input logic [IDX_W-1:0] idx);
    return (idx >= SKIP_LO) && (idx <= SKIP_HI);
  endfunction

  assign firstIdx = dirRight ? '0 : LAST_IDX;
  assign lastIdx  = dirRight ? LAST_IDX : '0;
  assign writing  = startIn || active;
  assign curIdx   = startIn ? firstIdx : ptr;
  assign isLast   = (curIdx == lastIdx);

  always_comb begin
    if (dirRight) begin
      nextIdx = curIdx + 1'b1;
      if (reducedMode && curIdx == SKIP_BEFORE) nextIdx = SKIP_AFTER;
    end else begin
      nextIdx = curIdx - 1'b1;
      if (reducedMode && curIdx == SKIP_AFTER) nextIdx = SKIP_BEFORE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      ptr      <= '0;
      cascReg  <= 1'b0;
      loadPrev <= 1'b0;
    end else begin
      loadPrev <= loadStrobe;
      cascReg  <= writing && isLast;
      if (writing) begin
        if (isLast) begin
          active <= 1'b0;
        end else begin
          active <= 1'b1;
          ptr    <= nextIdx;
        end
      end
    end
  end

  assign ctrl.wrEn      = writing;
  assign ctrl.swapColor = !dirRight;
  assign ctrl.loadHold  = loadStrobe && !loadPrev;
  assign wrIdx          = curIdx;
  assign cascPulse      = cascReg;

  a_r5_cascade_one_period: assert property (@(posedge clk) disable iff (rst)
    cascReg |=> !cascReg);
  a_r4_idle_after_last: assert property (@(posedge clk) disable iff (rst)
    (writing && isLast) |=> !active);
  a_r2_start_begins_line: assert property (@(posedge clk) disable iff (rst)
    startIn |=> active);
  a_r6_pointer_skips_group: assert property (@(posedge clk) disable iff (rst)
    (writing && reducedMode && !inSkip(curIdx))
      |=> (!active || !reducedMode || !inSkip(ptr)));
endmodule

// File: rtl/colsamp_datapath.sv
module colsamp_datapath
  import colsamp_pkg::*;
#(
  parameter int NUM_POS    = 103,
  parameter int DW         = 6,
  parameter int SKIP_FIRST = 51,
  parameter int SKIP_COUNT = 3,
  localparam int IDX_W  = $clog2(NUM_POS),
  localparam int SLOT_W = 3 * DW,
  localparam int ROW_W  = NUM_POS * SLOT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  sampCtrl_t        ctrl,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             reducedMode,
  input  logic [DW-1:0]    busX,
  input  logic [DW-1:0]    busY,
  input  logic [DW-1:0]    busZ,
  output logic [ROW_W-1:0] colOut
);
  logic [ROW_W-1:0]  sampRow;
  logic [ROW_W-1:0]  holdRow;
  logic [SLOT_W-1:0] wrWord;

  // slot layout: X low, Y middle, Z high
  assign wrWord = ctrl.swapColor ? {busX, busY, busZ} : {busZ, busY, busX};

  for (genvar p = 0; p < NUM_POS; p++) begin : g_pos
    localparam bit SKIPPABLE = (p >= SKIP_FIRST - 1) && (p <= SKIP_FIRST + SKIP_COUNT - 2);

    always_ff @(posedge clk) begin
      if (rst) begin
        sampRow[p*SLOT_W +: SLOT_W] <= '0;
      end else if (ctrl.wrEn && wrIdx == IDX_W'(p)) begin
        sampRow[p*SLOT_W +: SLOT_W] <= wrWord;
      end
    end

    if (SKIPPABLE) begin : g_masked
      assign colOut[p*SLOT_W +: SLOT_W] = reducedMode ? '0 : holdRow[p*SLOT_W +: SLOT_W];
    end else begin : g_plain
      assign colOut[p*SLOT_W +: SLOT_W] = holdRow[p*SLOT_W +: SLOT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) holdRow <= '0;
    else if (ctrl.loadHold) holdRow <= sampRow;
  end

  a_r8_load_copies_row: assert property (@(posedge clk) disable iff (rst)
    ctrl.loadHold |=> (holdRow == $past(sampRow)));
  a_r9_hold_kept: assert property (@(posedge clk) disable iff (rst)
    !ctrl.loadHold |=> $stable(holdRow));
endmodule

// File: rtl/colsamp_top.sv
module colsamp_top
  import colsamp_pkg::*;
#(
  parameter int NUM_POS    = 103,
  parameter int DW         = 6,
  parameter int SKIP_FIRST = 51,
  parameter int SKIP_COUNT = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      dirRight,
  input  logic                      reducedMode,
  input  logic                      loadStrobe,
  input  logic [DW-1:0]             busX,
  input  logic [DW-1:0]             busY,
  input  logic [DW-1:0]             busZ,
  input  logic                      pinLeftIn,
  output logic                      pinLeftOut,
  output logic                      pinLeftOe,
  input  logic                      pinRightIn,
  output logic                      pinRightOut,
  output logic                      pinRightOe,
  output logic [NUM_POS*3*DW-1:0]   colOut
);
  localparam int IDX_W = $clog2(NUM_POS);

  sampCtrl_t        ctrl;
  logic [IDX_W-1:0] wrIdx;
  logic             cascPulse;
  logic             startIn;

  assign startIn     = dirRight ? pinLeftIn : pinRightIn;
  assign pinLeftOe   = !dirRight;
  assign pinRightOe  = dirRight;
  assign pinLeftOut  = !dirRight && cascPulse;
  assign pinRightOut = dirRight && cascPulse;

  colsamp_ctrl #(
    .NUM_POS(NUM_POS), .SKIP_FIRST(SKIP_FIRST), .SKIP_COUNT(SKIP_COUNT)
  ) i_ctrl (
    .clk(clk), .rst(rst), .dirRight(dirRight), .reducedMode(reducedMode),
    .startIn(startIn), .loadStrobe(loadStrobe), .ctrl(ctrl), .wrIdx(wrIdx),
    .cascPulse(cascPulse)
  );

  colsamp_datapath #(
    .NUM_POS(NUM_POS), .DW(DW), .SKIP_FIRST(SKIP_FIRST), .SKIP_COUNT(SKIP_COUNT)
  ) i_datapath (
    .clk(clk), .rst(rst), .ctrl(ctrl), .wrIdx(wrIdx), .reducedMode(reducedMode),
    .busX(busX), .busY(busY), .busZ(busZ), .colOut(colOut)
  );

  a_r5_cascade_on_output_pin: assert property (@(posedge clk) disable iff (rst)
    (pinLeftOut || pinRightOut) |-> ((pinLeftOut && pinLeftOe) || (pinRightOut && pinRightOe)));
endmodule

// File: tb/test_colsamp_top.sv
module test_colsamp_top;
  localparam int PERIOD = 10;
  localparam int NP = 8;
  localparam int DW = 6;
  localparam int SF = 4;
  localparam int SC = 2;
  localparam int ROW_W = NP * 3 * DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dirRight = 1'b1, reducedMode = 1'b0, loadStrobe = 1'b0;
  logic [DW-1:0] busX = '0, busY = '0, busZ = '0;
  logic pinLeftIn = 1'b0, pinRightIn = 1'b0;
  logic pinLeftOut, pinLeftOe, pinRightOut, pinRightOe;
  logic [ROW_W-1:0] colOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [DW-1:0] expSamp [NP][3];
  logic [DW-1:0] expHold [NP][3];
  logic ldPrev = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  colsamp_top #(.NUM_POS(NP), .DW(DW), .SKIP_FIRST(SF), .SKIP_COUNT(SC)) i_colsamp_top (
    .clk(clk), .rst(rst), .dirRight(dirRight), .reducedMode(reducedMode),
    .loadStrobe(loadStrobe), .busX(busX), .busY(busY), .busZ(busZ),
    .pinLeftIn(pinLeftIn), .pinLeftOut(pinLeftOut), .pinLeftOe(pinLeftOe),
    .pinRightIn(pinRightIn), .pinRightOut(pinRightOut), .pinRightOe(pinRightOe),
    .colOut(colOut)
  );

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  function automatic bit skipped(input int p);
    return (p >= SF - 1) && (p <= SF + SC - 2);
  endfunction

  function automatic logic [DW-1:0] val(input int line, input int k, input int ch);
    return DW'((line * 7 + k * 3 + ch * 5 + 1) % 64);
  endfunction

  function automatic int lineLen(input bit red);
    return red ? NP - SC : NP;
  endfunction

  function automatic int posAt(input bit dirR, input bit red, input int k);
    int n = 0;
    for (int i = 0; i < NP; i++) begin
      int p = dirR ? i : NP - 1 - i;
      if (!(red && skipped(p))) begin
        if (n == k) return p;
        n++;
      end
    end
    return -1;
  endfunction

  // drive at a falling edge, model the rising edge, return at the next falling edge
  task automatic stepEdge(input bit st, input bit ld, input bit wr, input int pos, input int line, input int k);
    logic [DW-1:0] x, y, z;
    x = val(line, k, 0); y = val(line, k, 1); z = val(line, k, 2);
    busX = x; busY = y; busZ = z;
    pinLeftIn  = dirRight ? st : 1'b0;
    pinRightIn = dirRight ? 1'b0 : st;
    loadStrobe = ld;
    @(posedge clk);
    if (ld && !ldPrev) expHold = expSamp;
    ldPrev = ld;
    if (wr) begin
      expSamp[pos][0] = dirRight ? x : z;
      expSamp[pos][1] = y;
      expSamp[pos][2] = dirRight ? z : x;
    end
    @(negedge clk);
  endtask

  // R11 layout: position p at bit p*3*DW, slots X, Y, Z from low to high
  task automatic checkHold(input string req);
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < 3; s++)
        chk(req, $sformatf("pos%0d slot%0d (R11 layout)", p + 1, s),
            colOut[(p*3+s)*DW +: DW],
            (reducedMode && skipped(p)) ? 0 : expHold[p][s]);
  endtask

  task automatic checkPins(input string req, input bit casc);
    chk(req, "left oe", pinLeftOe, !dirRight);
    chk(req, "right oe", pinRightOe, dirRight);
    chk(req, "left out", pinLeftOut, casc && !dirRight);
    chk(req, "right out", pinRightOut, casc && dirRight);
  endtask

  task automatic loadPulse(input string req);
    stepEdge(1'b0, 1'b1, 1'b0, 0, 99, 0);
    checkHold(req);
    stepEdge(1'b0, 1'b0, 1'b0, 0, 99, 1);
  endtask

  // ldK >= 0: raise load at capture ldK and keep it high for the rest of the line
  task automatic runLine(input bit dirR, input bit red, input int line, input int ldK, input string req);
    int len;
    dirRight = dirR; reducedMode = red;
    len = lineLen(red);
    for (int k = 0; k < len; k++) begin
      stepEdge(k == 0, (ldK >= 0) && (k >= ldK), 1'b1, posAt(dirR, red, k), line, k);
      if (k == len / 2) checkHold("R9");
      if (k < len - 1) checkPins("R5", 1'b0);
    end
    checkPins(req, 1'b1);
    stepEdge(1'b0, (ldK >= 0), 1'b0, 0, line, len);
    checkPins("R5", 1'b0);
    // R4: idle edges with moving data, no start
    for (int j = 0; j < 3; j++) stepEdge(1'b0, (ldK >= 0), 1'b0, 0, line + 40, j);
    loadStrobe = 1'b0;
  endtask

  initial begin
    for (int p = 0; p < NP; p++) for (int s = 0; s < 3; s++) begin
      expSamp[p][s] = '0; expHold[p][s] = '0;
    end
    repeat (3) @(negedge clk);
    checkHold("R1");
    checkPins("R1", 1'b0);
    rst = 1'b0;
    @(negedge clk);
    checkHold("R1");
    checkPins("R1", 1'b0);

    // R2 and R3 with R7 (full width), then R6 (reduced width)
    runLine(1'b1, 1'b0, 1, -1, "R2");
    loadPulse("R7");
    runLine(1'b0, 1'b0, 2, -1, "R3");
    loadPulse("R3");
    runLine(1'b1, 1'b1, 3, -1, "R6");
    loadPulse("R6");
    runLine(1'b0, 1'b1, 4, -1, "R6");
    loadPulse("R4");
    reducedMode = 1'b0;
    @(negedge clk);
    checkHold("R7");

    // R8: partial copy, held strobe gives no second copy
    runLine(1'b1, 1'b0, 5, 3, "R8");
    checkHold("R8");
    loadPulse("R8");

    // R10: restart after two captures, in each direction
    for (int d = 0; d < 2; d++) begin
      dirRight = d[0]; reducedMode = 1'b0;
      stepEdge(1'b1, 1'b0, 1'b1, posAt(d[0], 1'b0, 0), 6 + d, 0);
      stepEdge(1'b0, 1'b0, 1'b1, posAt(d[0], 1'b0, 1), 6 + d, 1);
      runLine(d[0], 1'b0, 8 + d, -1, "R10");
      loadPulse("R10");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule